// File: doc/BRIEF.md
# Tagged Geometric-History Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It pairs an untagged base table of 2-bit counters, indexed by the low PC bits, with a set of tagged tables. Each tagged table is indexed and tagged by a hash of the PC and the newest bits of a global outcome history. The number of history bits doubles from one tagged table to the next. All tables are read in the same cycle. The tagged table that has a live entry with a matching partial tag and the longest history supplies the direction. When no tagged table matches, the base table decides.

A fetch stage offers a PC on the lookup stream. One cycle later the response stream carries the following:
- the predicted direction;
- the alternate direction, meaning what the next-best source would have said;
- the providing table number;
- the base index, plus every tagged index and tag that was computed.

The pipeline keeps that response as metadata. When the branch resolves, it returns the metadata on the update strobe together with the real outcome. The update then does four things. It trains the provider's counter. It adjusts the provider's usefulness. On a wrong prediction it claims an entry in a longer table. It shifts the outcome into the global history.

Back-pressure works as follows. The response register holds one result. `lk_ready` is high whenever that register is empty or is being drained in the same cycle. While `rs_valid` is high and `rs_ready` is low, every response field stays frozen. The update side is a plain strobe that is taken in any cycle. A lookup in the same cycle as an update sees the table and history contents from before that update.

Top module: `geo_hist_predictor`

## Requirements
- R1: A lookup is accepted on a clock edge where `lk_valid` and `lk_ready` are both high. Its result appears on the next cycle with `rs_valid` high. `lk_ready` is high exactly when `rs_valid` is low or `rs_ready` is high. While `rs_valid && !rs_ready`, all response fields hold their values.
- R2: The parameters are as follows:
  - four tagged tables with 64 entries each;
  - a 10-bit tag, a 3-bit direction counter and a 2-bit usefulness counter per entry;
  - a 256-entry base table of 2-bit counters.
  
  Tagged table t (t = 1..4) uses the newest 4·2^(t-1) history bits, that is 4, 8, 16 or 32 bits.
- R3: The base index is `lk_pc[7:0]`. After reset every base counter holds 1. A base counter predicts taken when its value is 2 or more.
- R4: The global history is 32 bits wide and is zero after reset. Bit 0 is the newest outcome. Each update shifts the history left by one and inserts `up_taken` at bit 0. Without an update the history is unchanged.
- R5: For tagged table t, form the 32-bit value `v = lk_pc ^ (history & mask_t)`, where mask_t keeps the table's history bits. Index bit k is the XOR of every `v[i]` with i mod 6 = k. Tag bit k is the XOR of every `v[i]` with i mod 10 = k. `rs_idx[(t-1)*6 +: 6]` and `rs_tag[(t-1)*10 +: 10]` carry these values.
- R6: A tagged table hits only if its indexed entry is valid and its stored tag equals the computed tag. `rs_provider` is the highest-numbered hitting table, or 0 when no table hits. `rs_pred` is bit 2 of the provider's counter, meaning the counter is 4 or more, or the base prediction when the provider is 0.
- R7: `rs_alt` is the direction of the next lower hitting tagged table below the provider. When there is none, `rs_alt` is the base prediction.
- R8: An update trains only the provider's counter, or the base counter at `up_base_idx` when the provider is 0. The counter counts up on taken and down on not-taken. A tagged counter saturates at 0 and 7. A base counter saturates at 0 and 3.
- R9: When the provider is nonzero and `up_pred != up_alt`, the provider's usefulness counter changes by one. It goes up if `up_pred == up_taken` and down otherwise, saturating at 0 and 3.
- R10: On an update with `up_pred != up_taken` and a provider below 4, the lowest-numbered table above the provider whose usefulness counter at its saved index is 0 receives a new entry. The entry is marked valid, takes the saved tag, starts with usefulness 0, and gets a counter of 4 if taken or 3 if not taken.
- R11: If that search finds no table with usefulness 0, nothing is allocated. Instead the usefulness counter at the saved index of every table above the provider goes down by one, saturating at 0.
- R12: After reset every tagged entry is invalid with usefulness 0, so early lookups report provider 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request can be accepted |
| lk_pc | input | 32 | Branch PC to predict |
| rs_valid | output | 1 | Response valid |
| rs_ready | input | 1 | Consumer accepts the response |
| rs_pred | output | 1 | Predicted direction (1 = taken) |
| rs_alt | output | 1 | Alternate direction |
| rs_provider | output | 3 | Providing table, 0 = base |
| rs_base_idx | output | 8 | Base table index used |
| rs_idx | output | 24 | Tagged indices, 6 bits per table, table 1 in the low bits |
| rs_tag | output | 40 | Tagged tags, 10 bits per table, table 1 in the low bits |
| up_valid | input | 1 | Update strobe |
| up_taken | input | 1 | Resolved outcome |
| up_pred | input | 1 | Saved prediction |
| up_alt | input | 1 | Saved alternate direction |
| up_provider | input | 3 | Saved provider number |
| up_base_idx | input | 8 | Saved base index |
| up_idx | input | 24 | Saved tagged indices |
| up_tag | input | 40 | Saved tagged tags |

## Verification
Three outcome patterns drive the bench:
- **Always taken, single PC.** The history fills with ones and stays there, so allocated entries are hit again. This separates allocation and provider choice from hashing mistakes.
- **Repeating three-taken, one-not-taken loop.** This needs the longer tables to learn the exit. It exposes wrong history slicing, wrong counter thresholds and wrong alternate selection.
- **Pseudo-random outcomes over eight PCs.** This fills the tables until no free entry exists. It reaches usefulness decay, aliasing and counter saturation.

A separate stalled lookup shows that responses freeze while the consumer holds off.

// File: rtl/geo_pred_pkg.sv
package geo_pred_pkg;

  // Action on an entry's usefulness counter during an update.
  typedef enum logic [1:0] {
    U_HOLD = 2'd0,
    U_INC  = 2'd1,
    U_DEC  = 2'd2
  } useful_op_e;

endpackage

// File: rtl/geo_tag_bank.sv
module geo_tag_bank
  import geo_pred_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int TAG_W = 10,
  parameter int CTR_W = 3,
  parameter int U_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic [CTR_W-1:0] rd_ctr,
  input  logic [IDX_W-1:0] up_idx,
  output logic [U_W-1:0]   up_u,
  input  logic             up_train,
  input  logic             up_taken,
  input  useful_op_e       up_uop,
  input  logic             up_alloc,
  input  logic [TAG_W-1:0] up_alloc_tag
);

  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] WEAK_T  = CTR_W'(1) << (CTR_W - 1);
  localparam logic [U_W-1:0]   U_MAX   = {U_W{1'b1}};

  logic             v_q   [DEPTH];
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [CTR_W-1:0] ctr_q [DEPTH];
  logic [U_W-1:0]   u_q   [DEPTH];

  assign rd_valid = v_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_ctr   = ctr_q[rd_idx];
  assign up_u     = u_q[up_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        v_q[i]   <= 1'b0;
        tag_q[i] <= '0;
        ctr_q[i] <= '0;
        u_q[i]   <= '0;
      end
    end else if (up_alloc) begin
      v_q[up_idx]   <= 1'b1;
      tag_q[up_idx] <= up_alloc_tag;
      ctr_q[up_idx] <= up_taken ? WEAK_T : WEAK_T - 1'b1;
      u_q[up_idx]   <= '0;
    end else begin
      if (up_train) begin
        if (up_taken && ctr_q[up_idx] != CTR_MAX)
          ctr_q[up_idx] <= ctr_q[up_idx] + 1'b1;
        else if (!up_taken && ctr_q[up_idx] != '0)
          ctr_q[up_idx] <= ctr_q[up_idx] - 1'b1;
      end
      case (up_uop)
        U_INC:   if (u_q[up_idx] != U_MAX) u_q[up_idx] <= u_q[up_idx] + 1'b1;
        U_DEC:   if (u_q[up_idx] != '0)    u_q[up_idx] <= u_q[up_idx] - 1'b1;
        default: ;
      endcase
    end
  end

  // R10: a fresh entry is live, tagged, weak and not yet useful
  assert_alloc_weak_R10: assert property (@(posedge clk) disable iff (!rst_n)
    up_alloc |=> (v_q[$past(up_idx)] && u_q[$past(up_idx)] == '0 &&
                  tag_q[$past(up_idx)] == $past(up_alloc_tag) &&
                  (ctr_q[$past(up_idx)] == WEAK_T || ctr_q[$past(up_idx)] == WEAK_T - 1'b1)));

  // R8: taken training below saturation moves the counter up by exactly one
  assert_train_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (up_train && !up_alloc && up_taken && ctr_q[up_idx] != CTR_MAX)
      |=> ctr_q[$past(up_idx)] == $past(ctr_q[up_idx]) + 1'b1);

endmodule

// File: rtl/geo_base_bank.sv
module geo_base_bank #(
  parameter int IDX_W = 8,
  parameter int CTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CTR_W-1:0] rd_ctr,
  input  logic [IDX_W-1:0] up_idx,
  input  logic             up_train,
  input  logic             up_taken
);

  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] WEAK_N  = (CTR_W'(1) << (CTR_W - 1)) - 1'b1;

  logic [CTR_W-1:0] ctr_q [DEPTH];

  assign rd_ctr = ctr_q[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= WEAK_N;
    end else if (up_train) begin
      if (up_taken && ctr_q[up_idx] != CTR_MAX)
        ctr_q[up_idx] <= ctr_q[up_idx] + 1'b1;
      else if (!up_taken && ctr_q[up_idx] != '0)
        ctr_q[up_idx] <= ctr_q[up_idx] - 1'b1;
    end
  end

  // R8: a not-taken update at the floor leaves the counter at zero
  assert_base_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (up_train && !up_taken && ctr_q[up_idx] == '0) |=> ctr_q[$past(up_idx)] == '0);

endmodule

// File: rtl/geo_provider_sel.sv
module geo_provider_sel #(
  parameter int NUM_TAGGED = 4,
  parameter int CTR_W      = 3,
  parameter int BASE_CTR_W = 2,
  parameter int PROV_W     = 3
) (
  input  logic [NUM_TAGGED-1:0]       hit,
  input  logic [NUM_TAGGED*CTR_W-1:0] ctr_flat,
  input  logic [BASE_CTR_W-1:0]       base_ctr,
  output logic [PROV_W-1:0]           provider,
  output logic                        pred,
  output logic                        alt
);

  logic p_dir;
  logic a_dir;
  logic [PROV_W-1:0] p_num;

  // Walk from shortest to longest history; each hit demotes the previous
  // choice to the alternate slot.
  always_comb begin
    p_dir = base_ctr[BASE_CTR_W-1];
    a_dir = base_ctr[BASE_CTR_W-1];
    p_num = '0;
    for (int t = 0; t < NUM_TAGGED; t++) begin
      if (hit[t]) begin
        a_dir = p_dir;
        p_dir = ctr_flat[t*CTR_W + CTR_W - 1];
        p_num = PROV_W'(t + 1);
      end
    end
  end

  assign provider = p_num;
  assign pred     = p_dir;
  assign alt      = a_dir;

endmodule

// File: rtl/geo_hist_predictor.sv
module geo_hist_predictor
  import geo_pred_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int NUM_TAGGED = 4,
  parameter int IDX_W      = 6,
  parameter int TAG_W      = 10,
  parameter int CTR_W      = 3,
  parameter int U_W        = 2,
  parameter int BASE_IDX_W = 8,
  parameter int BASE_CTR_W = 2,
  parameter int FIRST_HIST = 4,
  localparam int PROV_W    = $clog2(NUM_TAGGED + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        lk_valid,
  output logic                        lk_ready,
  input  logic [PC_W-1:0]             lk_pc,
  output logic                        rs_valid,
  input  logic                        rs_ready,
  output logic                        rs_pred,
  output logic                        rs_alt,
  output logic [PROV_W-1:0]           rs_provider,
  output logic [BASE_IDX_W-1:0]       rs_base_idx,
  output logic [NUM_TAGGED*IDX_W-1:0] rs_idx,
  output logic [NUM_TAGGED*TAG_W-1:0] rs_tag,
  input  logic                        up_valid,
  input  logic                        up_taken,
  input  logic                        up_pred,
  input  logic                        up_alt,
  input  logic [PROV_W-1:0]           up_provider,
  input  logic [BASE_IDX_W-1:0]       up_base_idx,
  input  logic [NUM_TAGGED*IDX_W-1:0] up_idx,
  input  logic [NUM_TAGGED*TAG_W-1:0] up_tag
);

  localparam int HIST_W = FIRST_HIST << (NUM_TAGGED - 1);
  localparam int MIX_W  = (PC_W > HIST_W) ? PC_W : HIST_W;

  logic [HIST_W-1:0] ghr_q;
  logic              lk_fire;

  logic [NUM_TAGGED-1:0]       hit;
  logic [NUM_TAGGED*IDX_W-1:0] lk_idx;
  logic [NUM_TAGGED*TAG_W-1:0] lk_tag;
  logic [NUM_TAGGED*CTR_W-1:0] lk_ctr;
  logic [NUM_TAGGED*U_W-1:0]   up_u_all;
  logic [NUM_TAGGED-1:0]       alloc_sel;
  logic [NUM_TAGGED-1:0]       decay_sel;
  logic [NUM_TAGGED-1:0]       free_slot;
  logic                        need_alloc;
  logic                        claimed;

  logic [BASE_CTR_W-1:0] base_ctr;
  logic [PROV_W-1:0]     sel_prov;
  logic                  sel_pred;
  logic                  sel_alt;

  assign lk_ready = !rs_valid || rs_ready;
  assign lk_fire  = lk_valid && lk_ready;

  // One tagged table per history length.
  for (genvar g = 0; g < NUM_TAGGED; g++) begin : g_tab
    localparam int HLEN = FIRST_HIST << g;
    localparam logic [HIST_W-1:0] HMASK = {HIST_W{1'b1}} >> (HIST_W - HLEN);

    logic [MIX_W-1:0] mix;
    logic [IDX_W-1:0] idx_c;
    logic [TAG_W-1:0] tag_c;
    logic             rd_v;
    logic [TAG_W-1:0] rd_tag;
    logic [CTR_W-1:0] rd_ctr;
    logic [U_W-1:0]   u_at_up;
    logic             train;
    useful_op_e       uop;

    assign mix = MIX_W'(lk_pc) ^ MIX_W'(ghr_q & HMASK);

    // XOR folding of the mixed value down to index and tag widths.
    always_comb begin
      idx_c = '0;
      tag_c = '0;
      for (int i = 0; i < MIX_W; i++) begin
        idx_c[i % IDX_W] = idx_c[i % IDX_W] ^ mix[i];
        tag_c[i % TAG_W] = tag_c[i % TAG_W] ^ mix[i];
      end
    end

    assign hit[g] = rd_v && (rd_tag == tag_c);
    assign lk_idx[g*IDX_W +: IDX_W] = idx_c;
    assign lk_tag[g*TAG_W +: TAG_W] = tag_c;
    assign lk_ctr[g*CTR_W +: CTR_W] = rd_ctr;
    assign up_u_all[g*U_W +: U_W]   = u_at_up;

    assign train = up_valid && (int'(up_provider) == g + 1);

    always_comb begin
      uop = U_HOLD;
      if (decay_sel[g])
        uop = U_DEC;
      else if (train && (up_pred != up_alt))
        uop = (up_pred == up_taken) ? U_INC : U_DEC;
    end

    geo_tag_bank #(
      .IDX_W (IDX_W),
      .TAG_W (TAG_W),
      .CTR_W (CTR_W),
      .U_W   (U_W)
    ) i_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .rd_idx       (idx_c),
      .rd_valid     (rd_v),
      .rd_tag       (rd_tag),
      .rd_ctr       (rd_ctr),
      .up_idx       (up_idx[g*IDX_W +: IDX_W]),
      .up_u         (u_at_up),
      .up_train     (train),
      .up_taken     (up_taken),
      .up_uop       (uop),
      .up_alloc     (alloc_sel[g]),
      .up_alloc_tag (up_tag[g*TAG_W +: TAG_W])
    );
  end

  geo_base_bank #(
    .IDX_W (BASE_IDX_W),
    .CTR_W (BASE_CTR_W)
  ) i_base (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (lk_pc[BASE_IDX_W-1:0]),
    .rd_ctr   (base_ctr),
    .up_idx   (up_base_idx),
    .up_train (up_valid && (up_provider == '0)),
    .up_taken (up_taken)
  );

  geo_provider_sel #(
    .NUM_TAGGED (NUM_TAGGED),
    .CTR_W      (CTR_W),
    .BASE_CTR_W (BASE_CTR_W),
    .PROV_W     (PROV_W)
  ) i_sel (
    .hit      (hit),
    .ctr_flat (lk_ctr),
    .base_ctr (base_ctr),
    .provider (sel_prov),
    .pred     (sel_pred),
    .alt      (sel_alt)
  );

  // Allocation on a wrong prediction: lowest longer table with a zero
  // usefulness counter; otherwise age all longer candidates.
  always_comb begin
    need_alloc = up_valid && (up_pred != up_taken) &&
                 (int'(up_provider) < NUM_TAGGED);
    for (int b = 0; b < NUM_TAGGED; b++)
      free_slot[b] = (b + 1 > int'(up_provider)) &&
                     (up_u_all[b*U_W +: U_W] == '0);
    alloc_sel = '0;
    claimed   = 1'b0;
    for (int b = 0; b < NUM_TAGGED; b++) begin
      if (need_alloc && free_slot[b] && !claimed) begin
        alloc_sel[b] = 1'b1;
        claimed      = 1'b1;
      end
    end
    for (int b = 0; b < NUM_TAGGED; b++)
      decay_sel[b] = need_alloc && (free_slot == '0) &&
                     (b + 1 > int'(up_provider));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ghr_q <= '0;
    else if (up_valid) ghr_q <= {ghr_q[HIST_W-2:0], up_taken};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid    <= 1'b0;
      rs_pred     <= 1'b0;
      rs_alt      <= 1'b0;
      rs_provider <= '0;
      rs_base_idx <= '0;
      rs_idx      <= '0;
      rs_tag      <= '0;
    end else if (lk_fire) begin
      rs_valid    <= 1'b1;
      rs_pred     <= sel_pred;
      rs_alt      <= sel_alt;
      rs_provider <= sel_prov;
      rs_base_idx <= lk_pc[BASE_IDX_W-1:0];
      rs_idx      <= lk_idx;
      rs_tag      <= lk_tag;
    end else if (rs_ready) begin
      rs_valid <= 1'b0;
    end
  end

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_ready) |=> (rs_valid && $stable(rs_pred) && $stable(rs_alt) &&
      $stable(rs_provider) && $stable(rs_idx) && $stable(rs_tag) && $stable(rs_base_idx)));

  assert_fill_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> rs_valid);

  assert_ghr_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> (ghr_q[0] == $past(up_taken)) &&
                 (ghr_q[HIST_W-1:1] == $past(ghr_q[HIST_W-2:0])));

  assert_ghr_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(ghr_q));

  assert_provider_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_prov != '0) |-> hit[sel_prov - 1'b1]);

  assert_longest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit >> sel_prov) == '0);

endmodule

// File: tb/test_geo_hist_predictor.sv
module test_geo_hist_predictor;

  typedef struct packed {
    logic        pred;
    logic        alt;
    logic [2:0]  prov;
    logic [7:0]  bidx;
    logic [23:0] idx;
    logic [39:0] tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [31:0] lk_pc = '0;
  logic        rs_valid;
  logic        rs_ready = 1'b1;
  logic        rs_pred, rs_alt;
  logic [2:0]  rs_provider;
  logic [7:0]  rs_base_idx;
  logic [23:0] rs_idx;
  logic [39:0] rs_tag;
  logic        up_valid = 1'b0;
  logic        up_taken = 1'b0;
  logic        up_pred = 1'b0;
  logic        up_alt = 1'b0;
  logic [2:0]  up_provider = '0;
  logic [7:0]  up_base_idx = '0;
  logic [23:0] up_idx = '0;
  logic [39:0] up_tag = '0;

  int n_checks = 0;
  int n_err = 0;
  bit done = 1'b0;
  exp_t q[$];

  // Reference state derived from the requirements.
  logic       mv [4][64];
  logic [9:0] mt [4][64];
  logic [2:0] mc [4][64];
  logic [1:0] mu [4][64];
  logic [1:0] mb [256];
  logic [31:0] mg;

  always #5 clk = ~clk;

  geo_hist_predictor i_geo_hist_predictor (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_pc(lk_pc),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_pred(rs_pred), .rs_alt(rs_alt),
    .rs_provider(rs_provider), .rs_base_idx(rs_base_idx), .rs_idx(rs_idx), .rs_tag(rs_tag),
    .up_valid(up_valid), .up_taken(up_taken), .up_pred(up_pred), .up_alt(up_alt),
    .up_provider(up_provider), .up_base_idx(up_base_idx), .up_idx(up_idx), .up_tag(up_tag)
  );

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  endtask

  function automatic exp_t model_lookup(input logic [31:0] pc);
    exp_t e;
    logic [31:0] v, mask;
    logic [5:0] ix [4];
    logic [9:0] tg;
    logic h [4];
    logic base_dir, got_p, got_a;
    int len;
    e = '0;
    e.bidx = pc[7:0];
    for (int t = 0; t < 4; t++) begin
      len = 4 << t;
      mask = (len >= 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 32'd1);
      v = pc ^ (mg & mask);
      ix[t] = '0;
      tg = '0;
      for (int i = 0; i < 32; i++) begin
        ix[t][i % 6] = ix[t][i % 6] ^ v[i];
        tg[i % 10]   = tg[i % 10] ^ v[i];
      end
      e.idx[t*6 +: 6]  = ix[t];
      e.tag[t*10 +: 10] = tg;
      h[t] = mv[t][ix[t]] && (mt[t][ix[t]] == tg);
    end
    base_dir = (mb[pc[7:0]] >= 2'd2);
    e.pred = base_dir;
    e.alt  = base_dir;
    got_p = 1'b0;
    got_a = 1'b0;
    for (int t = 3; t >= 0; t--) begin
      if (h[t] && !got_p) begin
        got_p = 1'b1;
        e.prov = 3'(t + 1);
        e.pred = (mc[t][ix[t]] >= 3'd4);
      end else if (h[t] && !got_a) begin
        got_a = 1'b1;
        e.alt = (mc[t][ix[t]] >= 3'd4);
      end
    end
    return e;
  endfunction

  task automatic model_update(input exp_t e, input logic tk);
    int p;
    logic [5:0] ix;
    bit placed;
    p = int'(e.prov);
    if (p == 0) begin
      if (tk && mb[e.bidx] != 2'd3) mb[e.bidx] = mb[e.bidx] + 2'd1;
      else if (!tk && mb[e.bidx] != 2'd0) mb[e.bidx] = mb[e.bidx] - 2'd1;
    end else begin
      ix = e.idx[(p-1)*6 +: 6];
      if (tk && mc[p-1][ix] != 3'd7) mc[p-1][ix] = mc[p-1][ix] + 3'd1;
      else if (!tk && mc[p-1][ix] != 3'd0) mc[p-1][ix] = mc[p-1][ix] - 3'd1;
      if (e.pred != e.alt) begin
        if (e.pred == tk && mu[p-1][ix] != 2'd3) mu[p-1][ix] = mu[p-1][ix] + 2'd1;
        else if (e.pred != tk && mu[p-1][ix] != 2'd0) mu[p-1][ix] = mu[p-1][ix] - 2'd1;
      end
    end
    if (e.pred != tk && p < 4) begin
      placed = 1'b0;
      for (int t = p; t < 4; t++) begin
        ix = e.idx[t*6 +: 6];
        if (!placed && mu[t][ix] == 2'd0) begin
          placed = 1'b1;
          mv[t][ix] = 1'b1;
          mt[t][ix] = e.tag[t*10 +: 10];
          mc[t][ix] = tk ? 3'd4 : 3'd3;
        end
      end
      if (!placed) begin
        for (int t = p; t < 4; t++) begin
          ix = e.idx[t*6 +: 6];
          if (mu[t][ix] != 2'd0) mu[t][ix] = mu[t][ix] - 2'd1;
        end
      end
    end
    mg = {mg[30:0], tk};
  endtask

  // Monitor: compare each delivered response with the oldest expectation.
  always @(negedge clk) begin
    if (rst_n && rs_valid && rs_ready) begin
      if (q.size() == 0) begin
        chk(1'b0, "R1 response without request", 64'(rs_valid), 64'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(rs_pred == e.pred, "R6 R8 R9 R10 R11 prediction", 64'(rs_pred), 64'(e.pred));
        chk(rs_alt == e.alt, "R7 alternate", 64'(rs_alt), 64'(e.alt));
        chk(rs_provider == e.prov, "R6 R12 provider", 64'(rs_provider), 64'(e.prov));
        chk(rs_base_idx == e.bidx, "R3 base index", 64'(rs_base_idx), 64'(e.bidx));
        chk(rs_idx == e.idx, "R2 R4 R5 indices", 64'(rs_idx), 64'(e.idx));
        chk(rs_tag == e.tag, "R5 tags", rs_tag[39:0], e.tag);
      end
    end
  end

  task automatic issue(input logic [31:0] pc, output exp_t e);
    e = model_lookup(pc);
    q.push_back(e);
    @(negedge clk);
    lk_valid = 1'b1;
    lk_pc = pc;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic resolve(input exp_t e, input logic tk);
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
    up_valid = 1'b1;
    up_taken = tk;
    up_pred = e.pred;
    up_alt = e.alt;
    up_provider = e.prov;
    up_base_idx = e.bidx;
    up_idx = e.idx;
    up_tag = e.tag;
    @(negedge clk);
    up_valid = 1'b0;
    model_update(e, tk);
  endtask

  task automatic step(input logic [31:0] pc, input logic tk);
    exp_t e;
    issue(pc, e);
    resolve(e, tk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    exp_t e;
    logic [2:0] s_prov;
    logic [39:0] s_tag;
    for (int t = 0; t < 4; t++)
      for (int i = 0; i < 64; i++) begin
        mv[t][i] = 1'b0; mt[t][i] = '0; mc[t][i] = '0; mu[t][i] = '0;
      end
    for (int i = 0; i < 256; i++) mb[i] = 2'd1;
    mg = '0;

    repeat (4) @(negedge clk);
    // R1 R12: idle handshake state during and after reset
    chk(lk_ready == 1'b1, "R1 lk_ready after reset", 64'(lk_ready), 64'd1);
    chk(rs_valid == 1'b0, "R1 R12 rs_valid after reset", 64'(rs_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Always-taken single branch: history saturates, allocations get reused.
    for (int k = 0; k < 40; k++) step(32'h0000_1234, 1'b1);

    // Loop branch with exit every fourth execution.
    for (int k = 0; k < 64; k++) step(32'h0000_2468, (k % 4) != 3);

    // R1: stalled consumer keeps the response and closes the request side.
    rs_ready = 1'b0;
    issue(32'h0000_0abc, e);
    @(negedge clk);
    chk(rs_valid == 1'b1, "R1 stalled rs_valid", 64'(rs_valid), 64'd1);
    chk(lk_ready == 1'b0, "R1 stalled lk_ready", 64'(lk_ready), 64'd0);
    s_prov = rs_provider;
    s_tag = rs_tag;
    repeat (3) @(negedge clk);
    chk(rs_valid == 1'b1, "R1 still valid", 64'(rs_valid), 64'd1);
    chk(rs_provider == s_prov, "R1 provider held", 64'(rs_provider), 64'(s_prov));
    chk(rs_tag == s_tag, "R1 tag held", rs_tag, s_tag);
    @(posedge clk);
    #2 rs_ready = 1'b1;
    resolve(e, 1'b0);

    // Pseudo-random outcomes over eight branches.
    lfsr = 16'hACE1;
    for (int k = 0; k < 300; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(32'h0000_4000 + {24'd0, lfsr[2:0], 5'd4}, lfsr[0] ? (lfsr[5] | lfsr[6]) : lfsr[7]);
    end

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R1 all responses delivered", 64'(q.size()), 64'd0);
    finish_run();
  end

endmodule